// File: doc/BRIEF.md
# Dual-Compare Pulse Generator

This block drives one output pin from two compare registers that watch an up-counting time base. The primary compare value sets where the pin goes high and the secondary compare value sets where it goes low. Two time bases are provided, and each one has its own period register, enable bit and count register. A select bit picks which of the two feeds the comparators. Each time base clears to zero when it reaches its period value. Every clock cycle a shared divide-by parameter decides whether the enabled time bases take a step.

A host loads the registers through a single-cycle write port and then writes a pulse mode into the control register. In one-shot mode the pin makes a single high pulse and then stays low. It is armed again only when the mode is written again, and the channel never has to be disabled in between. In repeating mode the pin makes one pulse in every timer period. Each falling-edge match sets an interrupt flag. The flag raises the interrupt line when the interrupt enable bit is set, and the host clears it by writing a one to it.

The channel controller is a state machine with five states:
- Off (`ST_OFF`).
- Waiting for the primary match (`ST_ARMED`).
- Pin high, waiting for the secondary match (`ST_HIGH`).
- Waiting for the count to leave the secondary value before the next period (`ST_REARM`).
- Finished one-shot (`ST_DONE`).

Its transitions are:
- arm: any state goes to `ST_ARMED` on a control write that carries a pulse mode.
- disable: any state goes to `ST_OFF` on a control write that carries any other mode.
- rise: `ST_ARMED` goes to `ST_HIGH` on a primary match.
- coincide: `ST_ARMED` goes to `ST_REARM` or `ST_DONE` when the primary and secondary values are equal.
- fall: `ST_HIGH` goes to `ST_REARM` in repeating mode, or to `ST_DONE` in one-shot mode, on a secondary match.
- resume: `ST_REARM` goes to `ST_ARMED` once the count differs from the secondary value.

Top module: `oc_pulse_gen`

## Requirements
- R1: A write to address 0 sets the control fields: bits [2:0] are the mode, bit 3 is the time-base select and bit 4 is the interrupt enable. Mode 3'b100 is one-shot and mode 3'b101 is repeating. A control write that carries a pulse mode drives the pin low from the next cycle and arms a new pulse, even if a pulse is already in progress.
- R2: While the channel is armed, the pin goes high in the clock cycle after the one in which the selected count equals the primary compare value (address 1).
- R3: While the pin is high, it goes low in the clock cycle after the one in which the selected count equals the secondary compare value (address 2). The same match sets the interrupt flag.
- R4: `irq_out` is high exactly when both the interrupt flag and the interrupt enable bit are 1.
- R5: In one-shot mode the pin produces exactly one pulse after arming and then stays low until the mode is written again.
- R6: In repeating mode the pin pulses once per timer period, so successive rising edges are period+1 counts apart, and every secondary match sets the flag.
- R7: Each time base advances only while its enable bit is 1 (address 3: bit 0 is time base A, bit 1 is time base B). It wraps to zero on the step after its count equals its period register (A at address 4, B at address 5). Writes to address 6 or 7 load the count of A or B.
- R8: When the select bit is 1, time base B drives both comparisons and time base A has no effect on the pin.
- R9: Mode 3'b000 and every mode value other than 3'b100 and 3'b101 hold the pin low. This is also the reset state, in which the pin and `irq_out` are low.
- R10: Writing 1 to bit 0 at address 8 clears the flag. When a clear and a set fall in the same cycle, the flag ends up set.
- R11: When the primary and secondary values are equal, the pin stays low and each match sets only the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | W | Write data |
| pulse_out | output | 1 | Compare output pin |
| irq_out | output | 1 | Interrupt request |

## Verification
In the same cycle, the falling-edge match can set the interrupt flag while the host writes a one to clear it. The bench uses a model to find the cycle in which the next step will hit the secondary match, and it places the clear write in exactly that cycle. It then expects `irq_out` to stay high. A second collision happens when a control rewrite lands on a compare match: the random phase hits this often, and the per-cycle model comparison judges it, with the rewrite taking priority.

// File: rtl/oc_pkg.sv
package oc_pkg;
    localparam int OC_AW = 4;

    localparam logic [OC_AW-1:0] ADR_CTRL  = 4'd0;
    localparam logic [OC_AW-1:0] ADR_PRI   = 4'd1;
    localparam logic [OC_AW-1:0] ADR_SEC   = 4'd2;
    localparam logic [OC_AW-1:0] ADR_TEN   = 4'd3;
    localparam logic [OC_AW-1:0] ADR_PER_A = 4'd4;
    localparam logic [OC_AW-1:0] ADR_PER_B = 4'd5;
    localparam logic [OC_AW-1:0] ADR_CNT_A = 4'd6;
    localparam logic [OC_AW-1:0] ADR_CNT_B = 4'd7;
    localparam logic [OC_AW-1:0] ADR_FCLR  = 4'd8;

    localparam logic [2:0] MODE_ONESHOT = 3'b100;
    localparam logic [2:0] MODE_REPEAT  = 3'b101;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_ARMED,
        ST_HIGH,
        ST_REARM,
        ST_DONE
    } oc_state_e;

    function automatic logic is_pulse_mode(input logic [2:0] m);
        return (m == MODE_ONESHOT) || (m == MODE_REPEAT);
    endfunction
endpackage

// File: rtl/oc_timebase.sv
module oc_timebase #(
    parameter int W   = 16,
    parameter int DIV = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] period,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] count,
    output logic         tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

    generate
        if (DIV <= 1) begin : g_nodiv
            assign tick = en;
        end else begin : g_div
            logic [PW-1:0] pre_q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pre_q <= '0;
                end else if (en) begin
                    if (pre_q == PW'(DIV - 1)) pre_q <= '0;
                    else                       pre_q <= pre_q + 1'b1;
                end
            end
            assign tick = en && (pre_q == PW'(DIV - 1));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (ld) begin
            count <= ld_val;
        end else if (tick) begin
            if (count == period) count <= '0;
            else                 count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/oc_host_regs.sv
module oc_host_regs
    import oc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [OC_AW-1:0] wr_addr,
    input  logic [W-1:0]     wr_data,
    output logic [2:0]       mode_q,
    output logic             tsel_q,
    output logic             ie_q,
    output logic [W-1:0]     pri_q,
    output logic [W-1:0]     sec_q,
    output logic             en_a_q,
    output logic             en_b_q,
    output logic [W-1:0]     per_a_q,
    output logic [W-1:0]     per_b_q,
    output logic             ld_a,
    output logic             ld_b,
    output logic             ctrl_wr,
    output logic             arm,
    output logic             flag_clr
);
    always_comb begin
        ctrl_wr  = wr_en && (wr_addr == ADR_CTRL);
        arm      = ctrl_wr && is_pulse_mode(wr_data[2:0]);
        ld_a     = wr_en && (wr_addr == ADR_CNT_A);
        ld_b     = wr_en && (wr_addr == ADR_CNT_B);
        flag_clr = wr_en && (wr_addr == ADR_FCLR) && wr_data[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= 3'b000;
            tsel_q  <= 1'b0;
            ie_q    <= 1'b0;
            pri_q   <= '0;
            sec_q   <= '0;
            en_a_q  <= 1'b0;
            en_b_q  <= 1'b0;
            per_a_q <= '1;
            per_b_q <= '1;
        end else if (wr_en) begin
            unique case (wr_addr)
                ADR_CTRL: begin
                    mode_q <= wr_data[2:0];
                    tsel_q <= wr_data[3];
                    ie_q   <= wr_data[4];
                end
                ADR_PRI:   pri_q   <= wr_data;
                ADR_SEC:   sec_q   <= wr_data;
                ADR_TEN: begin
                    en_a_q <= wr_data[0];
                    en_b_q <= wr_data[1];
                end
                ADR_PER_A: per_a_q <= wr_data;
                ADR_PER_B: per_b_q <= wr_data;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/oc_channel_fsm.sv
module oc_channel_fsm
    import oc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [2:0]   mode_q,
    input  logic         ctrl_wr,
    input  logic         arm,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] pri,
    input  logic [W-1:0] sec,
    input  logic         flag_clr,
    output oc_state_e    state,
    output logic         pin,
    output logic         flag_q
);
    oc_state_e next_state;
    logic      set_flag;
    logic      repeat_mode;
    logic      pri_hit;
    logic      sec_hit;

    always_comb begin
        repeat_mode = (mode_q == MODE_REPEAT);
        pri_hit     = (cnt == pri);
        sec_hit     = (cnt == sec);
    end

    always_comb begin
        next_state = state;
        set_flag   = 1'b0;
        if (ctrl_wr) begin
            next_state = arm ? ST_ARMED : ST_OFF;
        end else begin
            unique case (state)
                ST_OFF:   next_state = ST_OFF;
                ST_ARMED: begin
                    if (pri_hit) begin
                        if (pri == sec) begin
                            set_flag   = 1'b1;
                            next_state = repeat_mode ? ST_REARM : ST_DONE;
                        end else begin
                            next_state = ST_HIGH;
                        end
                    end
                end
                ST_HIGH: begin
                    if (sec_hit) begin
                        set_flag   = 1'b1;
                        next_state = repeat_mode ? ST_REARM : ST_DONE;
                    end
                end
                ST_REARM: begin
                    if (!sec_hit) next_state = ST_ARMED;
                end
                ST_DONE:  next_state = ST_DONE;
                default:  next_state = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= next_state;
    end

    always_comb begin
        pin = (state == ST_HIGH);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (set_flag) flag_q <= 1'b1;
        else if (flag_clr) flag_q <= 1'b0;
    end
endmodule

// File: rtl/oc_pulse_gen.sv
module oc_pulse_gen
    import oc_pkg::*;
#(
    parameter int W   = 16,
    parameter int DIV = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [OC_AW-1:0] wr_addr,
    input  logic [W-1:0]     wr_data,
    output logic             pulse_out,
    output logic             irq_out
);
    logic [2:0]   mode_q;
    logic         tsel_q, ie_q;
    logic [W-1:0] pri_q, sec_q, per_a_q, per_b_q;
    logic         en_a_q, en_b_q, ld_a, ld_b;
    logic         ctrl_wr, arm, flag_clr;
    logic [W-1:0] cnt_a, cnt_b, sel_cnt;
    logic         tick_a, tick_b;
    logic         flag_q;
    oc_state_e    fsm_state;

    oc_host_regs #(.W(W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .mode_q(mode_q), .tsel_q(tsel_q), .ie_q(ie_q),
        .pri_q(pri_q), .sec_q(sec_q), .en_a_q(en_a_q), .en_b_q(en_b_q),
        .per_a_q(per_a_q), .per_b_q(per_b_q), .ld_a(ld_a), .ld_b(ld_b),
        .ctrl_wr(ctrl_wr), .arm(arm), .flag_clr(flag_clr)
    );

    oc_timebase #(.W(W), .DIV(DIV)) tb_a_i (
        .clk(clk), .rst_n(rst_n), .en(en_a_q), .period(per_a_q),
        .ld(ld_a), .ld_val(wr_data), .count(cnt_a), .tick(tick_a)
    );

    oc_timebase #(.W(W), .DIV(DIV)) tb_b_i (
        .clk(clk), .rst_n(rst_n), .en(en_b_q), .period(per_b_q),
        .ld(ld_b), .ld_val(wr_data), .count(cnt_b), .tick(tick_b)
    );

    assign sel_cnt = tsel_q ? cnt_b : cnt_a;

    oc_channel_fsm #(.W(W)) fsm_i (
        .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .ctrl_wr(ctrl_wr),
        .arm(arm), .cnt(sel_cnt), .pri(pri_q), .sec(sec_q),
        .flag_clr(flag_clr), .state(fsm_state), .pin(pulse_out),
        .flag_q(flag_q)
    );

    assign irq_out = flag_q && ie_q;

    logic unused_tick_b;
    assign unused_tick_b = tick_b;
endmodule

// File: rtl/oc_pulse_gen_chk.sv
module oc_pulse_gen_chk
    import oc_pkg::*;
#(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         ctrl_wr,
    input logic         arm,
    input logic [2:0]   mode_q,
    input oc_state_e    state,
    input logic [W-1:0] sel_cnt,
    input logic [W-1:0] pri_q,
    input logic [W-1:0] sec_q,
    input logic         pulse_out,
    input logic         flag_q,
    input logic         tick_a,
    input logic         ld_a,
    input logic [W-1:0] cnt_a,
    input logic [W-1:0] per_a
);
    // R1
    arm_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (!pulse_out && state == ST_ARMED));

    // R9
    off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_pulse_mode(mode_q) |-> !pulse_out);

    // R2
    rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && sel_cnt == pri_q && pri_q != sec_q && !ctrl_wr)
        |=> pulse_out);

    // R3
    fall_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HIGH && sel_cnt == sec_q && !ctrl_wr)
        |=> (!pulse_out && flag_q));

    // R5
    single_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE && !ctrl_wr) |=> !pulse_out);

    // R7
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_a && !ld_a && cnt_a == per_a) |=> (cnt_a == '0));
endmodule

bind oc_pulse_gen oc_pulse_gen_chk #(.W(W)) chk_i (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .arm(arm),
    .mode_q(mode_q), .state(fsm_state), .sel_cnt(sel_cnt),
    .pri_q(pri_q), .sec_q(sec_q), .pulse_out(pulse_out),
    .flag_q(flag_q), .tick_a(tick_a), .ld_a(ld_a), .cnt_a(cnt_a),
    .per_a(per_a_q)
);

// File: tb/oc_pulse_gen_tb.sv
module oc_pulse_gen_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [3:0]   wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic         pulse_out, irq_out;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    oc_pulse_gen #(.W(W), .DIV(1)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pulse_out(pulse_out), .irq_out(irq_out)
    );

    // reference model; states: 0 off, 1 armed, 2 high, 3 rearm, 4 done
    int           m_st = 0;
    logic [2:0]   m_mode = 0;
    bit           m_tsel = 0, m_ie = 0, m_ea = 0, m_eb = 0, m_flag = 0;
    logic [W-1:0] m_pri = 0, m_sec = 0, m_pa = '1, m_pb = '1, m_ca = 0, m_cb = 0;

    function automatic logic [W-1:0] m_cnt();
        return m_tsel ? m_cb : m_ca;
    endfunction

    function automatic bit will_set();
        logic [W-1:0] c = m_cnt();
        return (m_st == 1 && c == m_pri && m_pri == m_sec) ||
               (m_st == 2 && c == m_sec);
    endfunction

    function automatic void model_step(bit w, logic [3:0] a, logic [W-1:0] d);
        logic [W-1:0] c = m_cnt();
        bit cont = (m_mode == 3'b101);
        bit set = 0;
        int nst = m_st;
        if (w && a == 0) nst = (d[2:0] == 3'b100 || d[2:0] == 3'b101) ? 1 : 0;
        else if (m_st == 1 && c == m_pri) begin
            if (m_pri == m_sec) begin set = 1; nst = cont ? 3 : 4; end
            else nst = 2;
        end else if (m_st == 2 && c == m_sec) begin
            set = 1; nst = cont ? 3 : 4;
        end else if (m_st == 3 && c != m_sec) nst = 1;
        m_st = nst;
        if (set) m_flag = 1;
        else if (w && a == 8 && d[0]) m_flag = 0;
        if (w && a == 6) m_ca = d;
        else if (m_ea) m_ca = (m_ca == m_pa) ? '0 : m_ca + 1'b1;
        if (w && a == 7) m_cb = d;
        else if (m_eb) m_cb = (m_cb == m_pb) ? '0 : m_cb + 1'b1;
        if (w) begin
            case (a)
                4'd0: begin m_mode = d[2:0]; m_tsel = d[3]; m_ie = d[4]; end
                4'd1: m_pri = d;
                4'd2: m_sec = d;
                4'd3: begin m_ea = d[0]; m_eb = d[1]; end
                4'd4: m_pa = d;
                4'd5: m_pb = d;
                default: ;
            endcase
        end
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cycle(input bit w, input logic [3:0] a, input logic [W-1:0] d);
        wr_en = w; wr_addr = a; wr_data = d;
        @(posedge clk);
        model_step(w, a, d);
        @(negedge clk);
        wr_en = 1'b0;
        check(pulse_out == (m_st == 2), "R2/R3 pin vs model", int'(pulse_out), int'(m_st == 2));
        check(irq_out == (m_flag && m_ie), "R4 irq vs model", int'(irq_out), int'(m_flag && m_ie));
    endtask

    task automatic wr(input logic [3:0] a, input logic [W-1:0] d);
        cycle(1'b1, a, d);
    endtask

    task automatic run(input int n, output int rises, output int highs, output int gap);
        int first = -1;
        bit prev = pulse_out;
        rises = 0; highs = 0; gap = -1;
        for (int i = 0; i < n; i++) begin
            cycle(1'b0, 4'd0, '0);
            if (pulse_out) highs++;
            if (pulse_out && !prev) begin
                rises++;
                if (first < 0) first = i;
                else if (gap < 0) gap = i - first;
            end
            prev = pulse_out;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int r, h, g;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check(pulse_out == 0 && irq_out == 0, "R9 reset low", int'(pulse_out | irq_out), 0);

        // R2 R3 R5 one-shot, width sec-pri
        wr(4'd4, 16'd20); wr(4'd1, 16'd3); wr(4'd2, 16'd8); wr(4'd6, 16'd0);
        wr(4'd0, 16'h0014); wr(4'd3, 16'd1);
        run(60, r, h, g);
        check(r == 1, "R5 one pulse", r, 1);
        check(h == 5, "R2/R3 width", h, 5);
        check(irq_out == 1, "R3 flag sets irq", int'(irq_out), 1);

        // R1 rewrite re-arms without disabling
        wr(4'd0, 16'h0014);
        check(pulse_out == 0, "R1 pin low after arm", int'(pulse_out), 0);
        run(50, r, h, g);
        check(r == 1, "R1 rearm gives pulse", r, 1);

        // R10 clear
        wr(4'd8, 16'd1);
        check(irq_out == 0, "R10 clear", int'(irq_out), 1'b0);

        // R6 repeating
        wr(4'd0, 16'h0015);
        run(100, r, h, g);
        check(r >= 4, "R6 repeats", r, 4);
        check(g == 21, "R6 period spacing", g, 21);
        check(irq_out == 1, "R6 flag set", int'(irq_out), 1);

        // R10 set wins over clear in same cycle
        wr(4'd8, 16'd1);
        for (int i = 0; i < 40 && !will_set(); i++) cycle(1'b0, 4'd0, '0);
        wr(4'd8, 16'd1);
        check(irq_out == 1, "R10 set wins", int'(irq_out), 1);
        wr(4'd8, 16'd1);
        check(irq_out == 0, "R10 clear alone", int'(irq_out), 0);

        // R11 equal compares
        wr(4'd1, 16'd5); wr(4'd2, 16'd5); wr(4'd0, 16'h0014);
        run(50, r, h, g);
        check(h == 0, "R11 no pulse", h, 0);
        check(irq_out == 1, "R11 flag only", int'(irq_out), 1);
        wr(4'd8, 16'd1);

        // R8 and R7: timer B selected but disabled
        wr(4'd1, 16'd2); wr(4'd2, 16'd4); wr(4'd7, 16'd0); wr(4'd5, 16'd10);
        wr(4'd0, 16'h001C);
        run(40, r, h, g);
        check(r == 0, "R7 disabled timer frozen", r, 0);
        wr(4'd3, 16'd3);
        run(40, r, h, g);
        check(r == 1, "R8 timer B drives", r, 1);
        check(h == 2, "R8 width on B", h, 2);

        // R9 off and unimplemented modes
        wr(4'd0, 16'h0005);
        for (int i = 0; i < 40 && !pulse_out; i++) cycle(1'b0, 4'd0, '0);
        wr(4'd0, 16'h0000);
        check(pulse_out == 0, "R9 mode 000 low", int'(pulse_out), 0);
        run(30, r, h, g);
        check(h == 0, "R9 stays off", h, 0);
        wr(4'd0, 16'h0007);
        run(30, r, h, g);
        check(h == 0, "R9 mode 111 low", h, 0);

        // random phase, lockstep against model
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(7) == 0) begin
                logic [3:0] a = 4'($urandom_range(8));
                logic [W-1:0] d;
                case (a)
                    4'd0: begin
                        logic [2:0] md;
                        case ($urandom_range(3))
                            0: md = 3'b100; 1: md = 3'b101; 2: md = 3'b000;
                            default: md = 3'($urandom_range(7));
                        endcase
                        d = {11'd0, 1'b1, 1'($urandom_range(1)), md};
                    end
                    4'd4, 4'd5: d = W'($urandom_range(20, 12));
                    4'd6, 4'd7, 4'd1, 4'd2: d = W'($urandom_range(11));
                    4'd3: d = W'($urandom_range(3));
                    default: d = W'($urandom_range(1));
                endcase
                cycle(1'b1, a, d);
            end else begin
                cycle(1'b0, 4'd0, '0);
            end
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule